// File: doc/BRIEF.md
# Next-Line Fetch Predictor Table

This block predicts, one cycle ahead, which instruction cache line the fetch unit reads next. A cache line holds eight instructions and is named by its way and set. Each line has two prediction slots, one per half of four instructions. Every slot stores a line name, never an instruction address. The cache may only read the line held in the current-prediction register, so that register is the block's main output.

Each fetch group sent to the block reads or trains one slot. A group with no delay slot of a predicted-taken control transfer reads the slot of the half where it starts. A group that holds such a delay slot uses the slot of the half that holds the delay slot: that slot is written with the transfer's target line, and the target becomes the prediction. Later the pipeline reports the line that was really needed. If it differs from the prediction, the block stalls fetch, reloads the prediction with the correct line and rewrites the slot that gave the wrong answer.

Top module: `nlp_fetch_predictor`

## Requirements
- R1: After reset, pred_valid_o and stall_o are 0 and every slot is invalid, so the first reads fall back to sequential prediction.
- R2: A line name is {way, set}, with the way in the upper bits. Slot index is {line, half}, where half 0 covers words 0 to 3 and half 1 covers words 4 to 7.
- R3: An accepted group with no delay slot whose start-half slot is invalid predicts the sequential line. From half 0 that is the same line. From half 1 it is {same way, (set+1) mod number of sets}.
- R4: An accepted group with ds_valid_i=1 loads target_line_i into pred_line_o on the next cycle. It also writes the target into slot {fetch_line_i, ds_half_i}. A later group starting in that half with no delay slot then predicts that target.
- R5: When delay slots in the same half train its slot more than once, the slot keeps the last target written.
- R6: A group with no delay slot reads only the slot of its start half. The other half's slot of the same line is not changed.
- R7: A misprediction makes stall_o high for exactly 2 cycles, starting the cycle after the misprediction. A misprediction is resolve_valid_i=1 with pred_valid_o=1, stall_o=0 and resolve_line_i different from pred_line_o.
- R8: On a misprediction, pred_line_o takes resolve_line_i on the next cycle. The slot that gave the wrong prediction is rewritten with resolve_line_i, unless that prediction itself came from an earlier correction.
- R9: While stall_o is high, fetch and resolve inputs are ignored. A fetch group in the same cycle as a misprediction is also dropped and trains nothing.
- R10: A resolve that matches pred_line_o, or that arrives while pred_valid_o=0, changes nothing.
- R11: pred_valid_o goes to 1 on the cycle after the first accepted fetch group and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_valid_i | input | 1 | A fetch group is presented this cycle |
| fetch_line_i | input | WAY_W+SET_W | Line {way, set} of the group |
| fetch_half_i | input | 1 | Half-line holding the group's first instruction |
| ds_valid_i | input | 1 | Group holds the delay slot of a predicted-taken transfer |
| ds_half_i | input | 1 | Half-line holding that delay slot |
| target_line_i | input | WAY_W+SET_W | Line of the transfer's target |
| resolve_valid_i | input | 1 | Resolved next line is presented |
| resolve_line_i | input | WAY_W+SET_W | Line that was really needed next |
| pred_valid_o | output | 1 | Prediction register holds a prediction |
| pred_line_o | output | WAY_W+SET_W | Line to read on the next access |
| stall_o | output | 1 | Fetch stall after a misprediction |

## Verification
Every result of an input cycle is registered once. The prediction, its valid flag and the start of the stall all change at the first clock edge after the inputs. The stall then holds through the following edge and drops at the third. The bench drives inputs on the falling edge. It moves its behavioural model forward by one cycle for those inputs, and it compares all three outputs on the next falling edge. The moment each output is checked is therefore exactly one edge after its cause.

// File: rtl/nlp_pkg.sv
package nlp_pkg;
  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_e;

  localparam int unsigned DEF_SET_W        = 6;
  localparam int unsigned DEF_WAY_W        = 1;
  localparam int unsigned DEF_STALL_CYCLES = 2;
endpackage

// File: rtl/nlp_slot_array.sv
module nlp_slot_array #(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned LINE_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_hit_o,
  output logic [LINE_W-1:0] rd_line_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [LINE_W-1:0] wr_line_i
);
  localparam int unsigned NUM_SLOTS = 1 << IDX_W;

  logic [NUM_SLOTS-1:0] vld_q;
  logic [LINE_W-1:0]    line_q [NUM_SLOTS];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) vld_q[s] <= 1'b0;
      else if (wr_en_i && wr_idx_i == IDX_W'(s)) vld_q[s] <= 1'b1;
    end

    always_ff @(posedge clk_i) begin
      if (wr_en_i && wr_idx_i == IDX_W'(s)) line_q[s] <= wr_line_i;
    end
  end

  assign rd_hit_o  = vld_q[rd_idx_i];
  assign rd_line_o = line_q[rd_idx_i];
endmodule

// File: rtl/nlp_next_sel.sv
module nlp_next_sel #(
  parameter int unsigned SET_W = 6,
  parameter int unsigned WAY_W = 1,
  localparam int unsigned LINE_W = SET_W + WAY_W,
  localparam int unsigned IDX_W  = LINE_W + 1
) (
  input  logic              fetch_half_i,
  input  logic [LINE_W-1:0] fetch_line_i,
  input  logic              ds_valid_i,
  input  logic              ds_half_i,
  input  logic [LINE_W-1:0] target_line_i,
  input  logic              slot_hit_i,
  input  logic [LINE_W-1:0] slot_line_i,
  output logic [IDX_W-1:0]  rd_idx_o,
  output logic [IDX_W-1:0]  src_idx_o,
  output logic [LINE_W-1:0] next_line_o
);
  import nlp_pkg::*;

  logic [SET_W-1:0]  cur_set;
  logic [WAY_W-1:0]  cur_way;
  logic [LINE_W-1:0] seq_line;
  logic [IDX_W-1:0]  train_idx;

  assign cur_set = fetch_line_i[SET_W-1:0];
  assign cur_way = fetch_line_i[LINE_W-1:SET_W];

  always_comb begin
    if (half_e'(fetch_half_i) == HALF_LO) seq_line = fetch_line_i;
    else seq_line = {cur_way, cur_set + SET_W'(1)};
  end

  assign rd_idx_o  = {fetch_line_i, fetch_half_i};
  assign train_idx = {fetch_line_i, ds_half_i};
  assign src_idx_o = ds_valid_i ? train_idx : rd_idx_o;

  always_comb begin
    if (ds_valid_i)      next_line_o = target_line_i;
    else if (slot_hit_i) next_line_o = slot_line_i;
    else                 next_line_o = seq_line;
  end
endmodule

// File: rtl/nlp_stall_timer.sv
module nlp_stall_timer #(
  parameter int unsigned STALL_CYCLES = 2,
  localparam int unsigned CNT_W = $clog2(STALL_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic stall_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (start_i)         cnt_q <= CNT_W'(STALL_CYCLES);
    else if (cnt_q != '0)     cnt_q <= cnt_q - CNT_W'(1);
  end

  assign stall_o = (cnt_q != '0);
endmodule

// File: rtl/nlp_fetch_predictor.sv
module nlp_fetch_predictor #(
  parameter int unsigned SET_W        = nlp_pkg::DEF_SET_W,
  parameter int unsigned WAY_W        = nlp_pkg::DEF_WAY_W,
  parameter int unsigned STALL_CYCLES = nlp_pkg::DEF_STALL_CYCLES,
  localparam int unsigned LINE_W = SET_W + WAY_W,
  localparam int unsigned IDX_W  = LINE_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_valid_i,
  input  logic [LINE_W-1:0] fetch_line_i,
  input  logic              fetch_half_i,
  input  logic              ds_valid_i,
  input  logic              ds_half_i,
  input  logic [LINE_W-1:0] target_line_i,
  input  logic              resolve_valid_i,
  input  logic [LINE_W-1:0] resolve_line_i,
  output logic              pred_valid_o,
  output logic [LINE_W-1:0] pred_line_o,
  output logic              stall_o
);
  logic              pred_vld_q;
  logic [LINE_W-1:0] pred_q;
  logic              src_vld_q;
  logic [IDX_W-1:0]  src_q;

  logic              miss;
  logic              accept;
  logic [IDX_W-1:0]  rd_idx;
  logic [IDX_W-1:0]  src_idx;
  logic              slot_hit;
  logic [LINE_W-1:0] slot_line;
  logic [LINE_W-1:0] next_line;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [LINE_W-1:0] wr_line;

  // a mispredict squashes the group fetched from the wrong line
  assign miss   = resolve_valid_i & pred_vld_q & ~stall_o & (resolve_line_i != pred_q);
  assign accept = fetch_valid_i & ~stall_o & ~miss;

  nlp_next_sel #(
    .SET_W (SET_W),
    .WAY_W (WAY_W)
  ) u_sel (
    .fetch_half_i  (fetch_half_i),
    .fetch_line_i  (fetch_line_i),
    .ds_valid_i    (ds_valid_i),
    .ds_half_i     (ds_half_i),
    .target_line_i (target_line_i),
    .slot_hit_i    (slot_hit),
    .slot_line_i   (slot_line),
    .rd_idx_o      (rd_idx),
    .src_idx_o     (src_idx),
    .next_line_o   (next_line)
  );

  always_comb begin
    wr_en   = 1'b0;
    wr_idx  = src_idx;
    wr_line = target_line_i;
    if (miss) begin
      wr_en   = src_vld_q;
      wr_idx  = src_q;
      wr_line = resolve_line_i;
    end else if (accept && ds_valid_i) begin
      wr_en = 1'b1;
    end
  end

  nlp_slot_array #(
    .IDX_W  (IDX_W),
    .LINE_W (LINE_W)
  ) u_slots (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_idx_i  (rd_idx),
    .rd_hit_o  (slot_hit),
    .rd_line_o (slot_line),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_line_i (wr_line)
  );

  nlp_stall_timer #(
    .STALL_CYCLES (STALL_CYCLES)
  ) u_stall (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (miss),
    .stall_o (stall_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pred_vld_q <= 1'b0;
      pred_q     <= '0;
      src_vld_q  <= 1'b0;
      src_q      <= '0;
    end else if (miss) begin
      pred_q    <= resolve_line_i;
      src_vld_q <= 1'b0;
    end else if (accept) begin
      pred_vld_q <= 1'b1;
      pred_q     <= next_line;
      src_vld_q  <= 1'b1;
      src_q      <= src_idx;
    end
  end

  assign pred_valid_o = pred_vld_q;
  assign pred_line_o  = pred_q;
endmodule

// File: rtl/nlp_fetch_predictor_chk.sv
module nlp_fetch_predictor_chk #(
  parameter int unsigned LINE_W       = 7,
  parameter int unsigned STALL_CYCLES = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fetch_valid_i,
  input logic              ds_valid_i,
  input logic [LINE_W-1:0] target_line_i,
  input logic              resolve_valid_i,
  input logic [LINE_W-1:0] resolve_line_i,
  input logic              pred_valid_o,
  input logic [LINE_W-1:0] pred_line_o,
  input logic              stall_o
);
  logic mis_seen;
  logic [31:0] run_q;

  assign mis_seen = resolve_valid_i && pred_valid_o && !stall_o && (resolve_line_i != pred_line_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      run_q <= '0;
    else if (stall_o) run_q <= run_q + 32'd1;
    else              run_q <= '0;
  end

  p_stall_after_miss_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mis_seen |=> stall_o);

  p_stall_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= STALL_CYCLES);

  p_pred_fix_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mis_seen |=> pred_line_o == $past(resolve_line_i));

  p_hold_in_stall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> $stable(pred_line_o));

  p_ds_target_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_valid_i && ds_valid_i && !stall_o && !mis_seen) |=> pred_line_o == $past(target_line_i));

  p_valid_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_valid_o |=> pred_valid_o);

  p_valid_after_fetch_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_valid_i && !stall_o) |=> pred_valid_o);
endmodule

bind nlp_fetch_predictor nlp_fetch_predictor_chk #(
  .LINE_W       (LINE_W),
  .STALL_CYCLES (STALL_CYCLES)
) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .fetch_valid_i   (fetch_valid_i),
  .ds_valid_i      (ds_valid_i),
  .target_line_i   (target_line_i),
  .resolve_valid_i (resolve_valid_i),
  .resolve_line_i  (resolve_line_i),
  .pred_valid_o    (pred_valid_o),
  .pred_line_o     (pred_line_o),
  .stall_o         (stall_o)
);

// File: tb/sim_nlp_fetch_predictor.sv
`timescale 1ns/1ps
module sim_nlp_fetch_predictor;
  localparam int SET_W  = 6;
  localparam int WAY_W  = 1;
  localparam int LINE_W = SET_W + WAY_W;
  localparam int NSETS  = 1 << SET_W;
  localparam int NSLOT  = 2 << LINE_W;

  logic clk = 0;
  logic rst_n = 0;
  logic fv = 0, fh = 0, dv = 0, dh = 0, rv = 0;
  logic [LINE_W-1:0] fl = '0, tl = '0, rl = '0;
  logic pv, st;
  logic [LINE_W-1:0] pl;

  always #2 clk = ~clk;

  nlp_fetch_predictor #(.SET_W(SET_W), .WAY_W(WAY_W), .STALL_CYCLES(2)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .fetch_valid_i(fv), .fetch_line_i(fl),
    .fetch_half_i(fh), .ds_valid_i(dv), .ds_half_i(dh), .target_line_i(tl),
    .resolve_valid_i(rv), .resolve_line_i(rl), .pred_valid_o(pv),
    .pred_line_o(pl), .stall_o(st));

  int checks = 0, failures = 0;
  bit done = 0;

  bit m_sv [NSLOT];
  int m_sd [NSLOT];
  int m_pred, m_cnt, m_src;
  bit m_pv, m_srcv;

  function automatic int seq_of(int line, int half);
    if (half == 0) return line;
    return (line / NSETS) * NSETS + ((line % NSETS) + 1) % NSETS;
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    check(tag, int'(pv), int'(m_pv), "pred_valid");
    check(tag, int'(st), (m_cnt != 0) ? 1 : 0, "stall");
    if (m_pv) check(tag, int'(pl), m_pred, "pred_line");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; fv = 0; dv = 0; rv = 0;
    foreach (m_sv[i]) m_sv[i] = 0;
    m_pv = 0; m_pred = 0; m_cnt = 0; m_srcv = 0; m_src = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    compare("R1");
  endtask

  task automatic cyc(bit a_fv, int a_fl, bit a_fh, bit a_dv, bit a_dh, int a_tl,
                     bit a_rv, int a_rl, string tag);
    bit stall, miss, acc;
    int ti, ri;
    fv = a_fv; fl = LINE_W'(a_fl); fh = a_fh; dv = a_dv; dh = a_dh;
    tl = LINE_W'(a_tl); rv = a_rv; rl = LINE_W'(a_rl);
    stall = (m_cnt != 0);
    miss  = a_rv && m_pv && !stall && (a_rl != m_pred);
    acc   = a_fv && !stall && !miss;
    if (miss) begin
      if (m_srcv) begin m_sv[m_src] = 1; m_sd[m_src] = a_rl; end
      m_pred = a_rl; m_srcv = 0; m_cnt = 2;
    end else begin
      if (m_cnt > 0) m_cnt--;
      if (acc) begin
        ti = a_fl * 2 + a_dh;
        ri = a_fl * 2 + a_fh;
        if (a_dv) begin
          m_sv[ti] = 1; m_sd[ti] = a_tl; m_pred = a_tl; m_src = ti;
        end else begin
          m_pred = m_sv[ri] ? m_sd[ri] : seq_of(a_fl, a_fh); m_src = ri;
        end
        m_pv = 1; m_srcv = 1;
      end
    end
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic fetch(int line, bit half, string tag);
    cyc(1, line, half, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic idle(string tag);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #400000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R3 / R11 / R2: sequential fallback incl. set wrap within a way
    idle("R11");
    fetch(5, 0, "R3");
    fetch(5, 1, "R3");
    fetch(127, 1, "R2");
    fetch(63, 1, "R2");
    // R4: delay slot in half 1 trains that slot
    cyc(1, 10, 0, 1, 1, 40, 0, 0, "R4");
    fetch(10, 1, "R4");
    fetch(10, 0, "R6");
    // R5: retrain same half
    cyc(1, 10, 1, 1, 1, 41, 0, 0, "R5");
    fetch(10, 0, "R6");
    fetch(10, 1, "R5");
    // R10: matching resolve
    cyc(0, 0, 0, 0, 0, 0, 1, 41, "R10");
    // R7 / R8 / R9: mispredict with squashed fetch, inputs during stall ignored
    cyc(1, 20, 0, 1, 0, 3, 1, 77, "R7");
    cyc(1, 20, 0, 1, 0, 3, 1, 9, "R9");
    cyc(1, 21, 1, 0, 0, 0, 1, 9, "R9");
    idle("R7");
    fetch(10, 1, "R8");
    fetch(20, 0, "R9");
    // R8: mispredict right after a correction rewrites nothing
    cyc(0, 0, 0, 0, 0, 0, 1, 50, "R8");
    idle("R7"); idle("R7");
    cyc(0, 0, 0, 0, 0, 0, 1, 51, "R8");
    idle("R7"); idle("R7");
    fetch(10, 1, "R8");
    // R10 / R1: resolve before any prediction, then slots cleared
    do_reset();
    cyc(0, 0, 0, 0, 0, 0, 1, 12, "R10");
    fetch(10, 1, "R1");
    // random mix on a small line window
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom_range(0, 9);
      cyc($urandom_range(0, 3) != 0, $urandom_range(0, 7) + 60 * $urandom_range(0, 1),
          1'($urandom_range(0, 1)), r < 3, 1'($urandom_range(0, 1)),
          $urandom_range(0, 127), r > 6, $urandom_range(0, 127), "R8");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule